// File: doc/BRIEF.md
# Flag-Gated Destination Commit

This unit keeps the two processor status flags, zero (Z) and sign (S), in a pair of flip-flops, and decides whether the current instruction's result may be written to its destination. The destination is either a general register or the program counter. The decoder supplies a 5-bit condition word for each instruction. The ALU supplies a flag-update strobe together with fresh Z and S values. The unit returns one commit enable, which the datapath uses to gate the register-file write or the program-counter load.

One mask-and-match word covers every case. This includes unconditional writes, writes that are suppressed (no-ops and memory stores), and the six relative-branch comparisons. The comparison uses only the flags already stored. An instruction is therefore steered by the flags that an earlier instruction left behind, and never by its own ALU outcome.

Top module: `cond_commit`

## Requirements
- R1: An active-low asynchronous reset clears both stored flags to 0. While in reset, the commit output is driven from Z=0 and S=0.
- R2: On a rising clock edge with `flag_we` high, the stored Z and S take `z_in` and `s_in`. With `flag_we` low, both stored flags keep their values.
- R3: The condition word is {bit 4 enable, bit 3 ignore Z, bit 2 ignore S, bit 1 wanted Z, bit 0 wanted S}. `commit` is 1 only when enable is 1 and each flag is either ignored or equal to its wanted value.
- R4: Any word with bit 4 equal to 0, including 00000 (never write), gives `commit` = 0, whatever the other bits and the flags.
- R5: Word 11100 (always) gives `commit` = 1 for every flag state.
- R6: The branch words behave as follows. 10110 commits when Z=1. 10100 commits when Z=0. 10000 commits when Z=0 and S=0. 11000 commits when S=0. 10001 commits when Z=0 and S=1. 11001 commits when S=1.
- R7: `commit` is combinational on the condition word and the stored flags. A flag update strobed in a cycle does not change `commit` until after the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| flag_we | input | 1 | Flag-update strobe from the ALU |
| z_in | input | 1 | New zero flag value |
| s_in | input | 1 | New sign flag value |
| cond | input | 5 | Condition word from the decoder |
| commit | output | 1 | Destination write enable |

## Verification
`commit` is due in the same cycle as the condition word, and it reflects only the flags stored at earlier edges. A strobed flag update shows up in `commit` only from the cycle after the edge that captures it. The bench drives inputs on the falling edge and compares `commit` against its model a quarter period later. It moves the model's flags only after the rising edge, so a same-cycle strobe is checked against the old flags. All 32 condition words are swept under each of the four flag states, then long random runs follow.

// File: rtl/cond_commit.sv
module cond_commit (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       flag_we,
  input  logic       z_in,
  input  logic       s_in,
  input  logic [4:0] cond,
  output logic       commit
);

  logic z_q, s_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      z_q <= 1'b0;
      s_q <= 1'b0;
    end else if (flag_we) begin
      z_q <= z_in;
      s_q <= s_in;
    end
  end

  wire en    = cond[4];
  wire z_ok  = cond[3] | (z_q == cond[1]);
  wire s_ok  = cond[2] | (s_q == cond[0]);

  assign commit = en & z_ok & s_ok;

  assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    flag_we |=> (z_q == $past(z_in)) && (s_q == $past(s_in)));

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_we |=> $stable(z_q) && $stable(s_q));

  assert_en_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !cond[4] |-> !commit);

  assert_always_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cond == 5'b11100) |-> commit);

  assert_eq_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cond == 5'b10110) |-> (commit == z_q));

  assert_lt_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cond == 5'b10001) |-> (commit == (!z_q && s_q)));

endmodule

// File: tb/cond_commit_bench.sv
module cond_commit_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flag_we = 1'b0, z_in = 1'b0, s_in = 1'b0;
  logic [4:0] cond = 5'b0;
  logic commit;

  int checks = 0, fails = 0;
  int mz = 0, ms = 0;

  always #10 clk = ~clk;

  cond_commit u_cond_commit (
    .clk(clk), .rst_n(rst_n), .flag_we(flag_we),
    .z_in(z_in), .s_in(s_in), .cond(cond), .commit(commit)
  );

  function automatic int model(input logic [4:0] c, input int z, input int s);
    int zmatch, smatch;
    if (c[4] == 1'b0) return 0;
    zmatch = (c[3] == 1'b1) || (z == int'(c[1]));
    smatch = (c[2] == 1'b1) || (s == int'(c[0]));
    return (zmatch != 0 && smatch != 0) ? 1 : 0;
  endfunction

  function automatic string tag_of(input logic [4:0] c);
    if (!c[4]) return "R4";
    if (c == 5'b11100) return "R5";
    if (c == 5'b10110 || c == 5'b10100 || c == 5'b10000 ||
        c == 5'b11000 || c == 5'b10001 || c == 5'b11001) return "R6";
    return "R3";
  endfunction

  task automatic step(input logic [4:0] c, input logic we, input logic z,
                      input logic s, input string tag);
    int exp;
    @(negedge clk);
    cond = c; flag_we = we; z_in = z; s_in = s;
    #5;
    exp = model(c, mz, ms);
    checks++;
    if (int'(commit) != exp) begin
      fails++;
      $display("FAIL %s cond=%b flags Z=%0d S=%0d: commit=%0d expected=%0d",
               (tag == "") ? tag_of(c) : tag, c, mz, ms, commit, exp);
    end
    @(posedge clk);
    #1;
    if (rst_n && we) begin mz = int'(z); ms = int'(s); end
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    checks++;
    $display("FAIL watchdog: run did not finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    // R1: flags cleared in reset, strobe ignored while in reset
    step(5'b10110, 1'b1, 1'b1, 1'b1, "R1");
    step(5'b10100, 1'b1, 1'b1, 1'b1, "R1");
    step(5'b10000, 1'b0, 1'b0, 1'b0, "R1");
    step(5'b10001, 1'b0, 1'b0, 1'b0, "R1");
    @(negedge clk); rst_n = 1'b1;

    // R3-R6: full sweep of words under each flag state
    for (int f = 0; f < 4; f++) begin
      step(5'b00000, 1'b1, logic'(f[1]), logic'(f[0]), "R2");
      for (int c = 0; c < 32; c++)
        step(5'(c), 1'b0, 1'b0, 1'b0, "");
    end

    // R7: same-cycle strobe does not affect commit; R2 hold
    step(5'b11100, 1'b1, 1'b0, 1'b0, "R2");
    step(5'b10110, 1'b1, 1'b1, 1'b0, "R7");
    step(5'b10110, 1'b0, 1'b0, 1'b1, "R7");
    step(5'b10110, 1'b0, 1'b0, 1'b1, "R2");
    step(5'b11001, 1'b1, 1'b0, 1'b1, "R7");
    step(5'b11001, 1'b0, 1'b1, 1'b0, "R2");
    step(5'b00011, 1'b0, 1'b0, 1'b0, "R4");
    step(5'b01111, 1'b0, 1'b0, 1'b0, "R4");

    // random traffic
    for (int i = 0; i < 3000; i++)
      step(5'($urandom_range(0, 31)), logic'($urandom_range(0, 1)),
           logic'($urandom_range(0, 1)), logic'($urandom_range(0, 1)), "");

    // R1: reset again mid-run
    @(negedge clk); rst_n = 1'b0; mz = 0; ms = 0;
    step(5'b10110, 1'b0, 1'b0, 1'b0, "R1");
    step(5'b11000, 1'b0, 1'b0, 1'b0, "R1");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule